// File: doc/BRIEF.md
# Packet Buffer DMA Pointer Controller

This block connects a host DMA engine to a 2K-byte on-chip packet buffer. It holds an 11-bit buffer address pointer and a data port. A small register window gives the host access to both. The pointer can advance by one after every data-port access, whether the access comes from programmed I/O or from a DMA cycle. A direction bit picks the transfer direction. With the bit set, received bytes flow from the buffer to the host. With it clear, bytes to be sent flow from the host into the buffer.

A DMA request is not raised when DMA is enabled. It is raised only by a later write of the pointer's low byte. This lets the host first handle the packet header bytes (source ID, destination ID, continuation pointer) by programmed I/O with DMA disabled. The host then enables DMA, points at the payload offset and hands over. Each acknowledged cycle moves one byte. The request then drops for one cycle and comes back for the next byte. A terminal-count pulse during an acknowledged cycle ends the run and sets an end-of-DMA status. That status drives the interrupt output when its mask bit allows it. The request pin and the terminal-count pin each have a selectable active level.

Top module: `pktbuf_dma_ptr`

## Requirements
- R1: After reset the control byte (register 0) reads 0x00, the pointer is 0, the status is clear, dma_dreq is low and irq is low.
- R2: A host write to register 1 loads pointer bits 10:8 from data bits 2:0. A write to register 2 loads pointer bits 7:0. Reading the same registers returns those fields, with the unused high bits of register 1 reading 0.
- R3: Register 3 is the data port. A host read returns the buffer byte at the pointer. A host write stores the byte there. When control bit 1 (auto-increment) is set, each access, host or DMA, advances the pointer by one, wrapping from 0x7FF to 0x000. When bit 1 is clear, the pointer holds.
- R4: Control bit 0 selects the DMA direction. With bit 0 at 1, an acknowledged cycle presents the buffer byte at the pointer on dma_rdata. With bit 0 at 0, an acknowledged cycle stores dma_wdata at the pointer.
- R5: With control bit 2 (DMA enable) set, a write to register 2 raises the request. Setting the enable bit on its own does not raise it, and neither does a write to register 1.
- R6: A cycle with dma_dack high while the request is raised is a transfer. After a transfer without terminal count, the request is inactive for exactly one cycle and then active again.
- R7: A transfer during which dma_tc is at its active level ends the run. The request stays inactive and status bit 0 (register 4) becomes 1. Control bit 4 set makes dma_tc active-low. Clear means active-high.
- R8: Control bit 3 set makes dma_dreq active-low. Clear means active-high.
- R9: irq is high exactly when status bit 0 is 1 and control bit 5 (interrupt mask) is 1. A host write of 1 in bit 0 to register 4 clears the status.
- R10: Clearing the DMA enable bit drops the request from the cycle after that write.
- R11: dma_dack while no request is raised is ignored. Neither the pointer nor the buffer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host register write strobe (one cycle per access) |
| host_rd | input | 1 | Host register read strobe (one cycle per access) |
| host_addr | input | 3 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid during the read strobe |
| dma_dreq | output | 1 | DMA request, level set by control bit 3 |
| dma_dack | input | 1 | DMA acknowledge, active high, one cycle per byte |
| dma_tc | input | 1 | Terminal count, level set by control bit 4 |
| dma_wdata | input | 8 | Byte from the DMA engine (host-to-buffer) |
| dma_rdata | output | 8 | Byte to the DMA engine (buffer-to-host) |
| irq | output | 1 | End-of-DMA interrupt, active high |

## Verification
The checker watches the request sequencing on every cycle. A rising request must follow either a low-byte pointer write with DMA enabled or a one-cycle gap. A transfer drops the request. A terminal-count transfer leaves the request off and the status set. With DMA disabled, the pin sits at its inactive level. The checker also covers pointer stepping on transfers, stray acknowledges and interrupt gating. Only the bench scenarios can show that the correct bytes cross in each direction, that the polarity bits work in all four combinations, that the pointer wraps, and that a stray acknowledge leaves the buffer contents alone.

// File: rtl/pktbuf_dma_pkg.sv
// Package: shared types for the packet buffer DMA pointer controller.
// Assumes an 8-bit host register window with a 3-bit register select.
package pktbuf_dma_pkg;

    localparam int BYTE_W = 8;

    // Host register select codes; the bench and software rely on these values.
    typedef enum logic [2:0] {
        RA_CTRL   = 3'd0,
        RA_PTR_HI = 3'd1,
        RA_PTR_LO = 3'd2,
        RA_DATA   = 3'd3,
        RA_STAT   = 3'd4
    } reg_addr_t;

    // Control byte, MSB first: bit5 mask .. bit0 direction.
    typedef struct packed {
        logic irq_mask;   // bit 5
        logic tc_low;     // bit 4
        logic dreq_low;   // bit 3
        logic dma_en;     // bit 2
        logic auto_inc;   // bit 1
        logic dir_rd;     // bit 0: 1 = buffer to host
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } dma_state_t;

endpackage

// File: rtl/pktbuf_buffer.sv
// Module: packet buffer storage.
// One combinational read port and one synchronous write port share the
// pointer as address. Contents are not reset.
module pktbuf_buffer #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one byte at the pointer when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Present the byte at the pointer.
    assign rdata = mem[addr];
endmodule

// File: rtl/pktbuf_dma_seq.sv
// Module: DMA request sequencer.
// Raises the request on an arming pointer write while enabled, drops it for
// one cycle after each transfer and stops on terminal count.
// Assumes dack is a one-cycle pulse per byte.
module pktbuf_dma_seq
    import pktbuf_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       dma_en,
    input  logic       dack,
    input  logic       tc_act,
    output logic       req,
    output logic       xfer,
    output logic       done_set,
    output dma_state_t state
);
    dma_state_t state_q, state_d;

    assign req      = (state_q == ST_REQ) && dma_en;
    assign xfer     = req && dack;
    assign done_set = xfer && tc_act;
    assign state    = state_q;

    // Next-state selection: disable wins, then re-arm, then handshake.
    always_comb begin
        state_d = state_q;
        if (!dma_en) begin
            state_d = ST_IDLE;
        end else if (arm) begin
            state_d = ST_REQ;
        end else begin
            case (state_q)
                ST_REQ:  if (dack) state_d = tc_act ? ST_IDLE : ST_GAP;
                ST_GAP:  state_d = ST_REQ;
                default: state_d = state_q;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/pktbuf_host_regs.sv
// Module: host register window.
// Holds the control byte, the buffer pointer and the end-of-DMA status.
// Decodes data-port accesses. A DMA transfer takes precedence over a
// host data-port access in the same cycle. A pointer write takes
// precedence over any increment.
module pktbuf_host_regs
    import pktbuf_dma_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [2:0]        host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              dma_xfer,
    input  logic              done_set,
    input  logic [7:0]        buf_rdata,
    output ctrl_t             ctrl,
    output logic [ADDR_W-1:0] ptr,
    output logic              ptr_wr,
    output logic              arm,
    output logic              pio_acc,
    output logic              pio_wr,
    output logic              done,
    output logic              irq
);
    localparam int HI_W = ADDR_W - 8;

    logic sel_ctrl, sel_hi, sel_lo, sel_data, sel_stat;

    assign sel_ctrl = (host_addr == RA_CTRL);
    assign sel_hi   = (host_addr == RA_PTR_HI);
    assign sel_lo   = (host_addr == RA_PTR_LO);
    assign sel_data = (host_addr == RA_DATA);
    assign sel_stat = (host_addr == RA_STAT);

    assign arm     = host_wr && sel_lo;
    assign ptr_wr  = host_wr && (sel_hi || sel_lo);
    assign pio_acc = (host_wr || host_rd) && sel_data && !dma_xfer;
    assign pio_wr  = host_wr && sel_data && !dma_xfer;

    // Control byte register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (host_wr && sel_ctrl) begin
            ctrl <= ctrl_t'(host_wdata[5:0]);
        end
    end

    // Buffer pointer: byte loads, then auto-increment on any data access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (host_wr && sel_hi) begin
            ptr[ADDR_W-1:8] <= host_wdata[HI_W-1:0];
        end else if (host_wr && sel_lo) begin
            ptr[7:0] <= host_wdata;
        end else if ((dma_xfer || pio_acc) && ctrl.auto_inc) begin
            ptr <= ptr + 1'b1;
        end
    end

    // End-of-DMA status: set wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
        end else if (done_set) begin
            done <= 1'b1;
        end else if (host_wr && sel_stat && host_wdata[0]) begin
            done <= 1'b0;
        end
    end

    assign irq = done && ctrl.irq_mask;

    // Host read multiplexer.
    always_comb begin
        host_rdata = '0;
        if (sel_ctrl)      host_rdata = {2'b00, ctrl};
        else if (sel_hi)   host_rdata = 8'(ptr[ADDR_W-1:8]);
        else if (sel_lo)   host_rdata = ptr[7:0];
        else if (sel_data) host_rdata = buf_rdata;
        else if (sel_stat) host_rdata = {7'd0, done};
    end
endmodule

// File: rtl/pktbuf_dma_ptr.sv
// Module: packet buffer DMA pointer controller (top).
// Joins the register window, the request sequencer and the buffer.
// Applies pin polarities and steers buffer writes from the host or the DMA side.
module pktbuf_dma_ptr
    import pktbuf_dma_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       dma_dreq,
    input  logic       dma_dack,
    input  logic       dma_tc,
    input  logic [7:0] dma_wdata,
    output logic [7:0] dma_rdata,
    output logic       irq
);
    ctrl_t             ctrl;
    logic [ADDR_W-1:0] ptr;
    logic              ptr_wr, arm, pio_acc, pio_wr, done;
    logic              req, xfer, done_set, tc_act;
    logic              buf_we;
    logic [7:0]        buf_wdata, buf_rdata;
    dma_state_t        dma_state;

    assign tc_act = dma_tc ^ ctrl.tc_low;

    pktbuf_host_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .dma_xfer   (xfer),
        .done_set   (done_set),
        .buf_rdata  (buf_rdata),
        .ctrl       (ctrl),
        .ptr        (ptr),
        .ptr_wr     (ptr_wr),
        .arm        (arm),
        .pio_acc    (pio_acc),
        .pio_wr     (pio_wr),
        .done       (done),
        .irq        (irq)
    );

    pktbuf_dma_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .dma_en   (ctrl.dma_en),
        .dack     (dma_dack),
        .tc_act   (tc_act),
        .req      (req),
        .xfer     (xfer),
        .done_set (done_set),
        .state    (dma_state)
    );

    // Buffer write steering: a host-to-buffer DMA transfer or a host data write.
    assign buf_we    = (xfer && !ctrl.dir_rd) || pio_wr;
    assign buf_wdata = xfer ? dma_wdata : host_wdata;

    pktbuf_buffer #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) buf_i (
        .clk   (clk),
        .we    (buf_we),
        .addr  (ptr),
        .wdata (buf_wdata),
        .rdata (buf_rdata)
    );

    assign dma_dreq  = req ^ ctrl.dreq_low;
    assign dma_rdata = buf_rdata;
endmodule

// File: rtl/pktbuf_dma_ptr_chk.sv
// Module: assertion checker for pktbuf_dma_ptr, attached by bind below.
// Observes internal hand-offs between the sequencer and the register window.
module pktbuf_dma_ptr_chk
    import pktbuf_dma_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              xfer,
    input logic              tc_act,
    input logic              arm,
    input dma_state_t        dma_state,
    input ctrl_t             ctrl,
    input logic              done,
    input logic              irq,
    input logic              dma_dreq,
    input logic              dma_dack,
    input logic [ADDR_W-1:0] ptr,
    input logic              ptr_wr,
    input logic              pio_acc
);
    assert_req_after_arm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> ($past(arm && ctrl.dma_en) || $past(dma_state == ST_GAP)));

    assert_gap_after_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !tc_act && !arm) |=> !req);

    assert_tc_ends_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && tc_act && !arm) |=> (!req && done));

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (done && ctrl.irq_mask));

    assert_disabled_idle_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.dma_en |-> (dma_dreq == ctrl.dreq_low));

    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && ctrl.auto_inc && !ptr_wr) |=> (ptr == $past(ptr) + 1'b1));

    assert_stray_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_dack && !req && !ptr_wr && !pio_acc) |=> $stable(ptr));
endmodule

bind pktbuf_dma_ptr pktbuf_dma_ptr_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .xfer      (xfer),
    .tc_act    (tc_act),
    .arm       (arm),
    .dma_state (dma_state),
    .ctrl      (ctrl),
    .done      (done),
    .irq       (irq),
    .dma_dreq  (dma_dreq),
    .dma_dack  (dma_dack),
    .ptr       (ptr),
    .ptr_wr    (ptr_wr),
    .pio_acc   (pio_acc)
);

// File: tb/pktbuf_dma_ptr_tb.sv
// Bench: sweeps both polarity bits, both directions and pointer wrap.
// Expected values are computed arithmetically.
module pktbuf_dma_ptr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       dma_dreq;
    logic       dma_dack = 1'b0, dma_tc = 1'b0;
    logic [7:0] dma_wdata = '0;
    logic [7:0] dma_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #10 clk = ~clk;

    pktbuf_dma_ptr dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .dma_dreq(dma_dreq), .dma_dack(dma_dack), .dma_tc(dma_tc),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .irq(irq)
    );

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic set_ptr(input int p);
        hw(3'd1, 8'((p >> 8) & 7));
        hw(3'd2, 8'(p & 255));
    endtask

    task automatic get_ptr(output int p);
        logic [7:0] h, l;
        hr(3'd1, h);
        hr(3'd2, l);
        p = {h, l};
    endtask

    // One DMA byte: called at a negedge with the request expected active.
    task automatic dma_one(input logic drl, input logic tcl, input logic last,
                           input logic rd, input logic [7:0] exp_rd,
                           input logic [7:0] wd, input string tag);
        #1 check({tag, " R6 request active before ack"}, dma_dreq, !drl);
        dma_dack = 1'b1; dma_tc = last ^ tcl; dma_wdata = wd;
        #1 if (rd) check({tag, " R4 read byte"}, dma_rdata, exp_rd);
        @(negedge clk);
        dma_dack = 1'b0; dma_tc = tcl;
        #1 check({tag, " R6/R7 request dropped after ack"}, dma_dreq, drl);
        if (!last) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1 check("R1 dreq", dma_dreq, 0);
        check("R1 irq", irq, 0);
        hr(3'd0, rv); check("R1 ctrl", rv, 0);
        get_ptr(p);   check("R1 ptr", p, 0);
        hr(3'd4, rv); check("R1 status", rv, 0);

        // R2 pointer load and readback
        set_ptr(16'h7FF); get_ptr(p); check("R2 ptr 7FF", p, 16'h7FF);
        hw(3'd1, 8'hFD); hr(3'd1, rv); check("R2 hi masked", rv, 8'h05);
        set_ptr(16'h2A5); get_ptr(p); check("R2 ptr 2A5", p, 16'h2A5);

        // R3 programmed I/O with wrap
        hw(3'd0, 8'h02);
        set_ptr(16'h7FC);
        for (int i = 0; i < 8; i++) hw(3'd3, pat(i));
        get_ptr(p); check("R3 wrap ptr", p, 16'h004);
        set_ptr(16'h7FC);
        for (int i = 0; i < 8; i++) begin
            hr(3'd3, rv); check("R3 pio read", rv, pat(i));
        end
        hw(3'd0, 8'h00);
        set_ptr(16'h7FE);
        hr(3'd3, rv); hr(3'd3, rv); check("R3 no-inc read", rv, pat(2));
        get_ptr(p); check("R3 no-inc ptr", p, 16'h7FE);

        // R4-R9 sweep over polarity pairs, both directions
        for (int pc = 0; pc < 4; pc++) begin
            logic drl, tcl;
            int base;
            logic [7:0] c;
            drl = pc[0]; tcl = pc[1];
            dma_tc = tcl;
            base = 16'h100 + pc * 16;
            hw(3'd0, 8'h02);
            set_ptr(base);
            for (int i = 0; i < 5; i++) hw(3'd3, pat(base + i));
            c = 8'(8'h20 | (tcl << 4) | (drl << 3) | 8'h07);
            hw(3'd0, c);
            #1 check("R5/R8 enable alone", dma_dreq, drl);
            hw(3'd1, 8'(base >> 8));
            #1 check("R5 hi write no request", dma_dreq, drl);
            hw(3'd2, 8'(base & 255));
            for (int i = 0; i < 5; i++)
                dma_one(drl, tcl, i == 4, 1'b1, pat(base + i), 8'h00, "read");
            @(negedge clk);
            #1 check("R7 stays off", dma_dreq, drl);
            check("R9 irq", irq, 1);
            hr(3'd4, rv); check("R7 status", rv, 1);
            get_ptr(p); check("R3 ptr after dma read", p, base + 5);
            hw(3'd4, 8'h01);
            #1 check("R9 cleared", irq, 0);

            // host-to-buffer
            base = 16'h200 + pc * 16;
            c = 8'(8'h20 | (tcl << 4) | (drl << 3) | 8'h06);
            hw(3'd0, c);
            set_ptr(base);
            for (int i = 0; i < 4; i++)
                dma_one(drl, tcl, i == 3, 1'b0, 8'h00, 8'(8'hA0 ^ (i + pc)), "write");
            hr(3'd4, rv); check("R7 status write", rv, 1);
            hw(3'd4, 8'h01);
            hw(3'd0, 8'h02);
            set_ptr(base);
            for (int i = 0; i < 4; i++) begin
                hr(3'd3, rv); check("R4 written byte", rv, 8'(8'hA0 ^ (i + pc)));
            end
        end
        dma_tc = 1'b0;

        // R9 masked interrupt
        hw(3'd0, 8'h07);
        set_ptr(16'h100);
        dma_one(1'b0, 1'b0, 1'b1, 1'b1, pat(16'h100), 8'h00, "masked");
        @(negedge clk);
        #1 check("R9 masked irq", irq, 0);
        hr(3'd4, rv); check("R9 masked status", rv, 1);
        hw(3'd0, 8'h27);
        #1 check("R9 mask set irq", irq, 1);
        hw(3'd4, 8'h01);
        #1 check("R9 clear irq", irq, 0);

        // R10 disable drops request
        set_ptr(16'h300);
        #1 check("R10 armed", dma_dreq, 1);
        hw(3'd0, 8'h03);
        #1 check("R10 dropped", dma_dreq, 0);

        // R11 stray acknowledge ignored
        hw(3'd0, 8'h02);
        set_ptr(16'h123);
        hw(3'd3, 8'h3C);
        set_ptr(16'h123);
        @(negedge clk);
        dma_dack = 1'b1; dma_wdata = 8'h55;
        @(negedge clk);
        dma_dack = 1'b0;
        get_ptr(p); check("R11 ptr", p, 16'h123);
        hw(3'd0, 8'h00);
        hr(3'd3, rv); check("R11 buffer", rv, 8'h3C);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule